// File: doc/BRIEF.md
# Self-Testing Reconfigurable Split Adder

A 64-bit carry-lookahead adder made of two identical 32-bit carry-lookahead halves placed behind a small input/output router. In normal operation the halves are chained into one full-width adder that takes a new operand pair every cycle and returns a registered 65-bit result one cycle later. The same two halves can also be turned on each other for on-line checking. In cross-check mode both halves add the same low 32-bit operand slices, both sums are returned, and a registered comparator flags any disagreement. Delay-test mode does the same comparison on launch/capture vector pairs.

When a half has been found faulty, the degraded mode computes a full 64-bit addition on the one half that is still healthy. It adds the low words in one cycle, keeps the carry, and adds the high words in the next cycle, so throughput drops to one result every two cycles. The same two-cycle schedule serves when a timing fault makes single-cycle operation unsafe. Choosing the mode and generating the test patterns are done outside the block.

The operand input is a valid/ready stream. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only during the second cycle of a degraded addition, and any input offered then is neither taken nor able to affect the result. The result side has no back-pressure: `out_done` is high for exactly one cycle for each completed result, and `out_sum`/`out_cout` hold that value until the next result.

Top module: `split_cla_adder`

## Requirements
- R1: With `in_mode`=0 (full), a beat taken at edge t gives `out_done`=1 in the cycle after t, with {`out_cout`,`out_sum`} equal to the exact 65-bit value of A + B + cin.
- R2: In full mode, beats offered on consecutive cycles are all taken (`in_ready` stays 1), and each one yields one result on the following cycle.
- R3: With `in_mode`=1 (cross-check), both halves add A[31:0] + B[31:0] + cin. The result has `out_sum`[31:0] from the lower half, `out_sum`[63:32] from the upper half and `out_cout` from the lower half, with done in the cycle after the beat is taken.
- R4: The comparator flags are registered. `out_mis_static` (cross-check) and `out_mis_delay` (delay test) can be high only in the cycle right after a checked result's done, and never both at once. Healthy halves give 0.
- R5: With `in_mode`=2 (delay test), beats alternate between launch and capture, starting with launch. A launch beat gives no done. A capture beat gives a result in the R3 layout one cycle after it is taken.
- R6: With `in_mode`=3 (degraded), `in_spare_up` picks the half that computes: 0 for the lower, 1 for the upper. A beat taken at edge t drops `in_ready` and gives no done in the next cycle. In the cycle after that it gives `out_done`=1 with the exact 65-bit A + B + cin.
- R7: During the second cycle of a degraded add, `in_ready`=0 and an offered beat is ignored: the result is unchanged and no extra done follows.
- R8: After reset: `in_ready`=1, `out_done`=0, both mismatch flags 0, and `out_sum`/`out_cout` are 0.
- R9: A beat taken in any mode other than 2 resets the delay-test sequence, so the next mode-2 beat is a launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take a beat |
| in_mode | input | 2 | 0 full, 1 cross-check, 2 delay test, 3 degraded |
| in_spare_up | input | 1 | Degraded mode: 1 selects the upper half, 0 the lower |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_cin | input | 1 | Carry-in |
| out_done | output | 1 | One-cycle result strobe |
| out_sum | output | 64 | Sum |
| out_cout | output | 1 | Carry-out |
| out_mis_static | output | 1 | Cross-check half mismatch |
| out_mis_delay | output | 1 | Delay-test half mismatch |

## Verification
The assertions assume that inputs are stable away from the rising edge, that `in_mode` is a legal 2-bit code when a beat is taken, and that a beat counts only when `in_ready` is high. The bench changes inputs only on falling edges. In degraded mode it deliberately keeps `in_valid` high with altered operands through the busy cycle, to show that those beats are refused. Operands come from a seeded `$urandom` together with directed carry cases: all-ones plus one, a carry crossing bit 31, and all-zero inputs.

// File: rtl/split_cla_pkg.sv
package split_cla_pkg;
  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_XCHK  = 2'd1,
    MODE_DELAY = 2'd2,
    MODE_HALF  = 2'd3
  } add_mode_e;
endpackage

// File: rtl/cla_half.sv
module cla_half #(
  parameter int W  = 32,
  parameter int GW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int NG = W / GW;

  logic [W-1:0]  gen, prp, carry;
  logic [NG-1:0] grp_g, grp_p;
  logic [NG:0]   grp_c;

  assign gen = a & b;
  assign prp = a ^ b;

  // group generate/propagate terms
  for (genvar k = 0; k < NG; k++) begin : g_grp
    logic [GW:0] cc;
    always_comb begin
      grp_g[k] = 1'b0;
      grp_p[k] = 1'b1;
      for (int j = 0; j < GW; j++) begin
        grp_g[k] = gen[k*GW+j] | (prp[k*GW+j] & grp_g[k]);
        grp_p[k] = grp_p[k] & prp[k*GW+j];
      end
    end
    always_comb begin
      cc[0] = grp_c[k];
      for (int j = 0; j < GW; j++)
        cc[j+1] = gen[k*GW+j] | (prp[k*GW+j] & cc[j]);
    end
    assign carry[k*GW +: GW] = cc[GW-1:0];
  end

  // lookahead across groups
  always_comb begin
    grp_c[0] = ci;
    for (int k = 0; k < NG; k++)
      grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);
  end

  assign s  = prp ^ carry;
  assign co = grp_c[NG];
endmodule

// File: rtl/half_router.sv
module half_router
  import split_cla_pkg::*;
#(
  parameter int HW = 32
) (
  input  add_mode_e         mode,
  input  logic              second,
  input  logic              sel_up,
  input  logic [2*HW-1:0]   a,
  input  logic [2*HW-1:0]   b,
  input  logic              ci,
  input  logic [HW-1:0]     hold_a,
  input  logic [HW-1:0]     hold_b,
  input  logic              hold_c,
  input  logic              lo_co,
  output logic [HW-1:0]     lo_a,
  output logic [HW-1:0]     lo_b,
  output logic              lo_ci,
  output logic [HW-1:0]     up_a,
  output logic [HW-1:0]     up_b,
  output logic              up_ci
);
  logic chain_en, up_ci_base;

  always_comb begin
    lo_a = '0; lo_b = '0; lo_ci = 1'b0;
    up_a = '0; up_b = '0; up_ci_base = 1'b0;
    chain_en = 1'b0;
    if (second) begin
      if (sel_up) begin
        up_a = hold_a; up_b = hold_b; up_ci_base = hold_c;
      end else begin
        lo_a = hold_a; lo_b = hold_b; lo_ci = hold_c;
      end
    end else begin
      unique case (mode)
        MODE_FULL: begin
          lo_a = a[HW-1:0];  lo_b = b[HW-1:0];  lo_ci = ci;
          up_a = a[2*HW-1:HW]; up_b = b[2*HW-1:HW];
          chain_en = 1'b1;
        end
        MODE_XCHK, MODE_DELAY: begin
          lo_a = a[HW-1:0]; lo_b = b[HW-1:0]; lo_ci = ci;
          up_a = a[HW-1:0]; up_b = b[HW-1:0]; up_ci_base = ci;
        end
        default: begin
          if (sel_up) begin
            up_a = a[HW-1:0]; up_b = b[HW-1:0]; up_ci_base = ci;
          end else begin
            lo_a = a[HW-1:0]; lo_b = b[HW-1:0]; lo_ci = ci;
          end
        end
      endcase
    end
  end

  assign up_ci = chain_en ? lo_co : up_ci_base;
endmodule

// File: rtl/half_compare.sv
module half_compare #(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic          dly_en,
  input  logic [HW-1:0] lo_s,
  input  logic [HW-1:0] up_s,
  input  logic          lo_c,
  input  logic          up_c,
  output logic          mis_static,
  output logic          mis_delay
);
  logic differ;
  assign differ = (lo_s != up_s) || (lo_c != up_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_static <= 1'b0;
      mis_delay  <= 1'b0;
    end else begin
      mis_static <= chk_en & differ;
      mis_delay  <= dly_en & differ;
    end
  end
endmodule

// File: rtl/split_cla_adder.sv
module split_cla_adder
  import split_cla_pkg::*;
#(
  parameter int W  = 64,
  parameter int GW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_mode,
  input  logic         in_spare_up,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_cin,
  output logic         out_done,
  output logic [W-1:0] out_sum,
  output logic         out_cout,
  output logic         out_mis_static,
  output logic         out_mis_delay
);
  localparam int HW = W / 2;

  add_mode_e     mode;
  logic          take;
  logic          busy_q, sel_q, launched_q, hold_c_q;
  logic [HW-1:0] hold_a_q, hold_b_q, lo_sum_q;
  logic          done_q, cout_q, up_co_q, chk_q, dly_q;
  logic [W-1:0]  sum_q;

  logic [HW-1:0] lo_a, lo_b, up_a, up_b, lo_s, up_s;
  logic          lo_ci, up_ci, lo_co, up_co, sel_now;

  assign mode     = add_mode_e'(in_mode);
  assign in_ready = ~busy_q;
  assign take     = in_valid & in_ready;
  assign sel_now  = busy_q ? sel_q : in_spare_up;

  half_router #(.HW(HW)) u_router (
    .mode(mode), .second(busy_q), .sel_up(sel_now),
    .a(in_a), .b(in_b), .ci(in_cin),
    .hold_a(hold_a_q), .hold_b(hold_b_q), .hold_c(hold_c_q),
    .lo_co(lo_co),
    .lo_a(lo_a), .lo_b(lo_b), .lo_ci(lo_ci),
    .up_a(up_a), .up_b(up_b), .up_ci(up_ci)
  );

  cla_half #(.W(HW), .GW(GW)) u_lo (.a(lo_a), .b(lo_b), .ci(lo_ci), .s(lo_s), .co(lo_co));
  cla_half #(.W(HW), .GW(GW)) u_up (.a(up_a), .b(up_b), .ci(up_ci), .s(up_s), .co(up_co));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sel_q <= 1'b0; launched_q <= 1'b0; hold_c_q <= 1'b0;
      hold_a_q <= '0; hold_b_q <= '0; lo_sum_q <= '0;
      done_q <= 1'b0; cout_q <= 1'b0; up_co_q <= 1'b0;
      chk_q <= 1'b0; dly_q <= 1'b0; sum_q <= '0;
    end else begin
      done_q <= 1'b0;
      chk_q  <= 1'b0;
      dly_q  <= 1'b0;
      if (busy_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        sum_q  <= {sel_q ? up_s : lo_s, lo_sum_q};
        cout_q <= sel_q ? up_co : lo_co;
      end else if (take) begin
        launched_q <= 1'b0;
        unique case (mode)
          MODE_FULL: begin
            done_q <= 1'b1;
            sum_q  <= {up_s, lo_s};
            cout_q <= up_co;
          end
          MODE_XCHK: begin
            done_q  <= 1'b1;
            chk_q   <= 1'b1;
            sum_q   <= {up_s, lo_s};
            cout_q  <= lo_co;
            up_co_q <= up_co;
          end
          MODE_DELAY: begin
            if (!launched_q) begin
              launched_q <= 1'b1;
            end else begin
              done_q  <= 1'b1;
              dly_q   <= 1'b1;
              sum_q   <= {up_s, lo_s};
              cout_q  <= lo_co;
              up_co_q <= up_co;
            end
          end
          default: begin
            busy_q   <= 1'b1;
            sel_q    <= in_spare_up;
            hold_a_q <= in_a[W-1:HW];
            hold_b_q <= in_b[W-1:HW];
            hold_c_q <= in_spare_up ? up_co : lo_co;
            lo_sum_q <= in_spare_up ? up_s : lo_s;
          end
        endcase
      end
    end
  end

  half_compare #(.HW(HW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_q), .dly_en(dly_q),
    .lo_s(sum_q[HW-1:0]), .up_s(sum_q[W-1:HW]),
    .lo_c(cout_q), .up_c(up_co_q),
    .mis_static(out_mis_static), .mis_delay(out_mis_delay)
  );

  assign out_done = done_q;
  assign out_sum  = sum_q;
  assign out_cout = cout_q;
endmodule

// File: rtl/split_cla_checks.sv
module split_cla_checks #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   in_mode,
  input logic         in_spare_up,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         in_cin,
  input logic         out_done,
  input logic [W-1:0] out_sum,
  input logic         out_cout,
  input logic         out_mis_static,
  input logic         out_mis_delay
);
  localparam int HW = W / 2;
  logic         take;
  logic [W:0]   exact;
  assign take  = in_valid & in_ready;
  assign exact = {1'b0, in_a} + {1'b0, in_b} + {{W{1'b0}}, in_cin};

  // R1
  full_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'd0) |=> (out_done && {out_cout, out_sum} == $past(exact)));

  // R3
  xchk_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'd1) |=> (out_done && out_sum[HW-1:0] == out_sum[W-1:HW]));

  // R6
  half_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'd3) |=> (!out_done && !in_ready));

  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (in_ready && out_done));

  // R4
  mis_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mis_static || out_mis_delay) |-> $past(out_done));

  // R4
  mis_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_mis_static, out_mis_delay}));
endmodule

bind split_cla_adder split_cla_checks #(.W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_spare_up(in_spare_up), .in_a(in_a), .in_b(in_b),
  .in_cin(in_cin), .out_done(out_done), .out_sum(out_sum), .out_cout(out_cout),
  .out_mis_static(out_mis_static), .out_mis_delay(out_mis_delay)
);

// File: tb/test_split_cla_adder.sv
module test_split_cla_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'd0;
  logic        in_spare_up = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        in_cin = 1'b0;
  logic        out_done, out_cout, out_mis_static, out_mis_delay;
  logic [63:0] out_sum;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  split_cla_adder i_split_cla_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_spare_up(in_spare_up), .in_a(in_a), .in_b(in_b),
    .in_cin(in_cin), .out_done(out_done), .out_sum(out_sum), .out_cout(out_cout),
    .out_mis_static(out_mis_static), .out_mis_delay(out_mis_delay)
  );

  function automatic logic [64:0] full_sum(input logic [63:0] a, b, input logic c);
    return {1'b0, a} + {1'b0, b} + {64'd0, c};
  endfunction

  function automatic logic [64:0] xchk_sum(input logic [63:0] a, b, input logic c);
    logic [32:0] lo;
    lo = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'd0, c};
    return {lo[32], lo[31:0], lo[31:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [64:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic s, input logic [63:0] a, b, input logic c);
    in_mode = m; in_spare_up = s; in_a = a; in_b = b; in_cin = c; in_valid = 1'b1;
  endtask

  // one beat in modes 0, 1 or 2 (capture); result checked a cycle later
  task automatic one_cycle_op(input logic [1:0] m, input logic [63:0] a, b, input logic c, input string tag);
    logic [64:0] exp;
    exp = (m == 2'd0) ? full_sum(a, b, c) : xchk_sum(a, b, c);
    @(negedge clk); drive(m, 1'b0, a, b, c);
    @(negedge clk); in_valid = 1'b0;
    chk(out_done == 1'b1, {tag, " done"}, {64'd0, out_done}, 65'd1);
    chk({out_cout, out_sum} == exp, {tag, " result"}, {out_cout, out_sum}, exp);
    if (m != 2'd0) begin
      @(negedge clk);
      // R4: flag one cycle after done, zero for healthy halves
      chk(!out_mis_static && !out_mis_delay && !out_done, "R4 mismatch flags",
          {63'd0, out_mis_static, out_mis_delay}, 65'd0);
    end
  endtask

  task automatic launch(input logic [63:0] a, b, input logic c);
    @(negedge clk); drive(2'd2, 1'b0, a, b, c);
    @(negedge clk); in_valid = 1'b0;
    chk(out_done == 1'b0, "R5 launch gives no done", {64'd0, out_done}, 65'd0);
  endtask

  task automatic half_op(input logic s, input logic [63:0] a, b, input logic c);
    logic [64:0] exp;
    exp = full_sum(a, b, c);
    @(negedge clk); drive(2'd3, s, a, b, c);
    @(negedge clk);
    // R7: keep offering altered data while busy
    in_a = ~a; in_b = b ^ 64'h5555_0000_AAAA_FFFF; in_cin = ~c; in_mode = 2'd0;
    chk(!in_ready && !out_done, "R6 first cycle busy", {63'd0, in_ready, out_done}, 65'd0);
    @(negedge clk); in_valid = 1'b0;
    chk(out_done && in_ready, "R6 done after two cycles", {63'd0, out_done, in_ready}, 65'd3);
    chk({out_cout, out_sum} == exp, "R6 degraded result", {out_cout, out_sum}, exp);
    @(negedge clk);
    chk(!out_done && {out_cout, out_sum} == exp, "R7 busy beat ignored", {out_cout, out_sum}, exp);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] pa, pb;
    logic        pc, have;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(in_ready && !out_done && !out_mis_static && !out_mis_delay && out_sum == 0 && !out_cout,
        "R8 reset state", {out_cout, out_sum}, 65'd0);
    rst_n = 1'b1;

    // R1 directed corners
    one_cycle_op(2'd0, '1, '1, 1'b1, "R1 all ones");
    one_cycle_op(2'd0, '0, '0, 1'b0, "R1 zeros");
    one_cycle_op(2'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, "R1 carry over bit 31");
    one_cycle_op(2'd0, '1, 64'd0, 1'b1, "R1 carry ripple to out");
    for (int i = 0; i < 40; i++)
      one_cycle_op(2'd0, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");

    // R2 back-to-back stream
    have = 1'b0; pa = '0; pb = '0; pc = 1'b0;
    for (int i = 0; i <= 30; i++) begin
      @(negedge clk);
      if (have) begin
        chk(out_done && {out_cout, out_sum} == full_sum(pa, pb, pc), "R2 stream result",
            {out_cout, out_sum}, full_sum(pa, pb, pc));
        chk(in_ready == 1'b1, "R2 ready held", {64'd0, in_ready}, 65'd1);
      end
      if (i < 30) begin
        pa = {$urandom, $urandom}; pb = {$urandom, $urandom}; pc = 1'($urandom);
        drive(2'd0, 1'b0, pa, pb, pc); have = 1'b1;
      end else in_valid = 1'b0;
    end

    // R3 cross-check
    one_cycle_op(2'd1, 64'h1234_5678_FFFF_FFFF, 64'h0, 1'b1, "R3 xchk carry");
    for (int i = 0; i < 20; i++)
      one_cycle_op(2'd1, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R3 xchk random");

    // R5 delay pairs
    for (int i = 0; i < 10; i++) begin
      launch({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
      one_cycle_op(2'd2, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R5 capture");
    end

    // R9 other mode resets launch/capture sequence
    launch(64'd5, 64'd6, 1'b0);
    one_cycle_op(2'd0, 64'd7, 64'd8, 1'b0, "R9 interleaved full");
    @(negedge clk); drive(2'd2, 1'b0, 64'd1, 64'd2, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    chk(out_done == 1'b0, "R9 next delay beat is launch", {64'd0, out_done}, 65'd0);
    one_cycle_op(2'd2, 64'd3, 64'd4, 1'b1, "R9 capture after relaunch");

    // R6/R7 degraded on each half
    half_op(1'b0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0);
    half_op(1'b1, '1, '1, 1'b1);
    for (int i = 0; i < 20; i++) begin
      half_op(1'b0, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
      half_op(1'b1, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule